// File: doc/BRIEF.md
# Key-Protected Flash Mode-Entry Register

This block holds a 16-bit control register that moves a flash controller into program/erase mode for one of two flash regions. Software reaches it over a plain register bus that carries an address, write data, a size flag (word or byte), a write strobe and combinational read data. A write only changes the mode when it is a full word and its upper byte holds the key value 0xAA. It must also arrive while the write-enable pin monitor and the controller-ready flag are both high. A mode can only be entered from the all-clear state. Any write that is rejected or out of sequence clears the register; it is not silently dropped.

Internally the register is a four-state machine. The states are CLEAR (0x0000), AREA0 (0x0001, region 0 in program/erase), AREA1 (0x0002, region 1 in program/erase) and BOTH (0x0003, illegal). Each cycle a decoder turns the bus and status inputs into one event: NONE, SOFT (soft reset), BYTE (byte-size write), BADKEY (word write with a wrong key), KEYED_EN (keyed word write with the enable conditions met) or AUTOCLR (ready high while the write-enable monitor is low). The transitions are:
- CLEAR goes to the written mode bits on KEYED_EN.
- AREA0, AREA1 and BOTH go to CLEAR on SOFT, BYTE, BADKEY, AUTOCLR or KEYED_EN.
- Every state holds on NONE.

When the register reaches BOTH, a sticky illegal-error flag and the command lock assert. They stay set until a hardware reset or a soft reset.

Top module: `fme_top`

## Requirements
- R1: A low rst_n, or a high soft_rst at a clock edge, returns the register to 0x0000 and clears ill_err and cmd_lock.
- R2: When bus_addr equals REG_ADDR, bus_rdata is {14'b0, mode}, so bits 15:2 (key and reserved) always read 0. At any other address bus_rdata is 0.
- R3: A word write to REG_ADDR with bus_wdata[15:8]=0xAA, wen_mon=1 and ctl_ready=1, made while the register is 0x0000, loads bus_wdata[1:0] into the mode bits at the next edge. Bit 0 selects region 0 and bit 1 selects region 1.
- R4: A keyed word write under the enable conditions, made while the register is nonzero, clears it to 0x0000 whatever data it carries. This includes writing 0 to a mode bit.
- R5: Any byte-size write (bus_word=0) to REG_ADDR clears the register.
- R6: A word write to REG_ADDR whose bits 15:8 are not 0xAA clears the register.
- R7: A keyed word write made while wen_mon or ctl_ready is 0 leaves the register unchanged, except where R8 applies.
- R8: While ctl_ready=1 and wen_mon=0, the register clears at the next edge without any bus write. While ctl_ready=0, the register holds.
- R9: When the register holds 0x0003, ill_err and cmd_lock are 1 from that same edge, and both stay 1 after the register is cleared, until R1 applies.
- R10: Writes to any address other than REG_ADDR have no effect.
- R11: soft_rst takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous reset request from the companion reset register |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 16 | Write data; bits 15:8 are the key, bits 1:0 the mode bits |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Combinational read data |
| wen_mon | input | 1 | Write-enable pin monitor |
| ctl_ready | input | 1 | Flash controller ready flag |
| mode_out | output | 2 | Program/erase mode bits for region 1 and region 0 |
| ill_err | output | 1 | Sticky illegal-setting error flag |
| cmd_lock | output | 1 | Sticky command-lock indication |

## Verification
The entry path is tried with each region code and with the illegal both-bits code. This separates correct mode loading from a design that masks or drops one bit, and it shows that the lock is sticky. Keyed writes are repeated in non-clear states to show they clear rather than re-enter. Byte-size writes, wrong keys and wrong addresses are each sent against a nonzero register, which tells "clear", "ignore" and "accept" apart. The two status inputs are toggled one at a time, which separates a blocked write, a hold and an automatic clear. Soft reset is raised together with a valid entry write to expose the priority between them.

// File: rtl/fme_pkg.sv
package fme_pkg;
    localparam int DATA_W = 16;
    localparam int KEY_W  = 8;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ST_CLEAR = 2'b00,
        ST_AREA0 = 2'b01,
        ST_AREA1 = 2'b10,
        ST_BOTH  = 2'b11
    } fme_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_SOFT,
        EV_BYTE,
        EV_BADKEY,
        EV_KEYED_EN,
        EV_AUTOCLR
    } fme_event_e;
endpackage

// File: rtl/fme_decode.sv
module fme_decode
    import fme_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02,
    parameter logic [7:0]  KEY_CODE = 8'hAA
) (
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_word,
    input  logic              bus_we,
    input  logic              wen_mon,
    input  logic              ctl_ready,
    output fme_event_e        evt,
    output logic [MODE_W-1:0] wr_mode
);
    localparam int KEY_LSB = DATA_W - KEY_W;

    logic hit;
    logic key_ok;
    logic enable_ok;
    logic auto_clr;
    logic unused_reserved;

    assign hit       = bus_we && (bus_addr == REG_ADDR);
    assign key_ok    = (bus_wdata[DATA_W-1:KEY_LSB] == KEY_CODE);
    assign enable_ok = wen_mon && ctl_ready;
    assign auto_clr  = ctl_ready && !wen_mon;
    assign wr_mode   = bus_wdata[MODE_W-1:0];
    assign unused_reserved = ^bus_wdata[KEY_LSB-1:MODE_W];

    always_comb begin
        evt = EV_NONE;
        if (soft_rst) begin
            evt = EV_SOFT;
        end else if (hit && !bus_word) begin
            evt = EV_BYTE;
        end else if (hit && !key_ok) begin
            evt = EV_BADKEY;
        end else if (hit && enable_ok) begin
            evt = EV_KEYED_EN;
        end else if (auto_clr) begin
            evt = EV_AUTOCLR;
        end
    end
endmodule

// File: rtl/fme_fsm.sv
module fme_fsm
    import fme_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fme_event_e        evt,
    input  logic [MODE_W-1:0] wr_mode,
    output fme_state_e        state_q,
    output fme_state_e        state_d,
    output logic [MODE_W-1:0] mode_bits
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (evt == EV_KEYED_EN) begin
                    state_d = fme_state_e'(wr_mode);
                end
            end
            ST_AREA0, ST_AREA1, ST_BOTH: begin
                if (evt != EV_NONE) begin
                    state_d = ST_CLEAR;
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAR: mode_bits = 2'b00;
            ST_AREA0: mode_bits = 2'b01;
            ST_AREA1: mode_bits = 2'b10;
            ST_BOTH:  mode_bits = 2'b11;
            default:  mode_bits = 2'b00;
        endcase
    end
endmodule

// File: rtl/fme_lock.sv
module fme_lock
    import fme_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  fme_state_e state_d,
    output logic       lock_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (soft_rst) begin
            lock_q <= 1'b0;
        end else if (state_d == ST_BOTH) begin
            lock_q <= 1'b1;
        end
    end
endmodule

// File: rtl/fme_top.sv
module fme_top
    import fme_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02,
    parameter logic [7:0]        KEY_CODE = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_word,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    input  logic              wen_mon,
    input  logic              ctl_ready,
    output logic [1:0]        mode_out,
    output logic              ill_err,
    output logic              cmd_lock
);
    fme_event_e        evt;
    logic [MODE_W-1:0] wr_mode;
    fme_state_e        state_q;
    fme_state_e        state_d;
    logic [MODE_W-1:0] mode_bits;
    logic              lock_q;

    fme_decode #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR),
        .KEY_CODE(KEY_CODE)
    ) u_decode (
        .soft_rst (soft_rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_word (bus_word),
        .bus_we   (bus_we),
        .wen_mon  (wen_mon),
        .ctl_ready(ctl_ready),
        .evt      (evt),
        .wr_mode  (wr_mode)
    );

    fme_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wr_mode  (wr_mode),
        .state_q  (state_q),
        .state_d  (state_d),
        .mode_bits(mode_bits)
    );

    fme_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .state_d (state_d),
        .lock_q  (lock_q)
    );

    assign mode_out  = mode_bits;
    assign ill_err   = lock_q;
    assign cmd_lock  = lock_q;
    assign bus_rdata = (bus_addr == REG_ADDR)
                     ? {{(DATA_W-MODE_W){1'b0}}, mode_bits}
                     : '0;
endmodule

// File: rtl/fme_checker.sv
module fme_checker #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02,
    parameter logic [7:0]        KEY_CODE = 8'hAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_word,
    input logic              bus_we,
    input logic [15:0]       bus_rdata,
    input logic              wen_mon,
    input logic              ctl_ready,
    input logic [1:0]        mode_out,
    input logic              ill_err,
    input logic              cmd_lock
);
    logic hit;
    assign hit = bus_we && (bus_addr == REG_ADDR);

    always_comb begin
        assert_rsv_zero_R2: assert (bus_rdata[15:2] == 14'h0000);
    end

    assert_soft_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_out == 2'b00) && !cmd_lock);

    assert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && hit && bus_word && bus_wdata[15:8] == KEY_CODE
         && wen_mon && ctl_ready && mode_out == 2'b00)
        |=> mode_out == $past(bus_wdata[1:0]));

    assert_reentry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_word && bus_wdata[15:8] == KEY_CODE && wen_mon
         && ctl_ready && mode_out != 2'b00) |=> mode_out == 2'b00);

    assert_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bus_word) |=> mode_out == 2'b00);

    assert_badkey_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_word && bus_wdata[15:8] != KEY_CODE) |=> mode_out == 2'b00);

    assert_autoclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ready && !wen_mon) |=> mode_out == 2'b00);

    assert_lock_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 2'b11) |-> (cmd_lock && ill_err));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock && !soft_rst) |=> cmd_lock);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !hit && !(ctl_ready && !wen_mon)) |=> $stable(mode_out));
endmodule

bind fme_top fme_checker #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .KEY_CODE(KEY_CODE)
) u_fme_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_word (bus_word),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .wen_mon  (wen_mon),
    .ctl_ready(ctl_ready),
    .mode_out (mode_out),
    .ill_err  (ill_err),
    .cmd_lock (cmd_lock)
);

// File: tb/tb_fme_top.sv
`timescale 1ns/1ps
module tb_fme_top;
    localparam int         ADDR_W = 8;
    localparam logic [7:0] RA     = 8'h02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [7:0]  bus_addr = RA;
    logic [15:0] bus_wdata = '0;
    logic        bus_word = 1'b1;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        wen_mon = 1'b1;
    logic        ctl_ready = 1'b1;
    logic [1:0]  mode_out;
    logic        ill_err;
    logic        cmd_lock;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    fme_top #(.ADDR_W(ADDR_W), .REG_ADDR(RA), .KEY_CODE(8'hAA)) dut (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic word);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_word = word; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = RA;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 mode after reset", {14'b0, mode_out}, 16'h0000);
        check("R1 lock after reset", {14'b0, ill_err, cmd_lock}, 16'h0000);
        check("R2 rdata after reset", bus_rdata, 16'h0000);
    endtask

    task automatic t_entry();
        wr(RA, 16'hAA01, 1'b1);
        check("R3 enter region0", bus_rdata, 16'h0001);
        check("R9 no lock legal", {15'b0, cmd_lock}, 16'h0000);
        wr(RA, 16'hAA02, 1'b1);
        check("R4 keyed write nonzero clears", bus_rdata, 16'h0000);
        wr(RA, 16'hAAFE, 1'b1);
        check("R3 enter region1 reserved ignored", bus_rdata, 16'h0002);
        wr(RA, 16'hAA00, 1'b1);
        check("R4 write zero clears", bus_rdata, 16'h0000);
    endtask

    task automatic t_rejects();
        wr(RA, 16'hAA02, 1'b1);
        wr(RA, 16'hAA02, 1'b0);
        check("R5 byte write clears", {14'b0, mode_out}, 16'h0000);
        wr(RA, 16'hAA01, 1'b0);
        check("R5 byte write no entry", {14'b0, mode_out}, 16'h0000);
        wr(RA, 16'hAA01, 1'b1);
        wr(RA, 16'h5501, 1'b1);
        check("R6 bad key clears", {14'b0, mode_out}, 16'h0000);
        wr(RA, 16'h0002, 1'b1);
        check("R6 zero key no entry", {14'b0, mode_out}, 16'h0000);
    endtask

    task automatic t_blocked();
        ctl_ready = 1'b0; wen_mon = 1'b1;
        wr(RA, 16'hAA01, 1'b1);
        check("R7 ready low blocks entry", {14'b0, mode_out}, 16'h0000);
        ctl_ready = 1'b1;
        wr(RA, 16'hAA01, 1'b1);
        ctl_ready = 1'b0;
        wr(RA, 16'hAA00, 1'b1);
        check("R7 ready low keeps mode", {14'b0, mode_out}, 16'h0001);
        wen_mon = 1'b0;
        idle();
        check("R8 ready low holds", {14'b0, mode_out}, 16'h0001);
        ctl_ready = 1'b1;
        idle();
        check("R8 auto clear", {14'b0, mode_out}, 16'h0000);
        wr(RA, 16'hAA01, 1'b1);
        check("R7 wen low blocks entry", {14'b0, mode_out}, 16'h0000);
        wen_mon = 1'b1;
    endtask

    task automatic t_addr();
        wr(RA, 16'hAA02, 1'b1);
        wr(8'h03, 16'h5500, 1'b0);
        check("R10 other addr ignored", {14'b0, mode_out}, 16'h0002);
        bus_addr = 8'h40;
        #0.5;
        check("R2 other addr reads zero", bus_rdata, 16'h0000);
        bus_addr = RA;
        wr(RA, 16'hAA00, 1'b1);
        wr(8'h00, 16'hAA01, 1'b1);
        check("R10 other addr no entry", {14'b0, mode_out}, 16'h0000);
    endtask

    task automatic t_soft();
        @(negedge clk);
        soft_rst = 1'b1; bus_addr = RA; bus_wdata = 16'hAA01; bus_word = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; bus_we = 1'b0;
        check("R11 soft reset beats write", {14'b0, mode_out}, 16'h0000);
    endtask

    task automatic t_illegal();
        wr(RA, 16'hAA03, 1'b1);
        check("R9 both bits held", bus_rdata, 16'h0003);
        check("R9 lock set", {14'b0, ill_err, cmd_lock}, 16'h0003);
        wr(RA, 16'h0000, 1'b0);
        check("R9 cleared value", {14'b0, mode_out}, 16'h0000);
        check("R9 lock sticky", {14'b0, ill_err, cmd_lock}, 16'h0003);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        check("R1 soft reset clears lock", {14'b0, ill_err, cmd_lock}, 16'h0000);
        wr(RA, 16'hAA03, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 hw reset clears all", {13'b0, mode_out, cmd_lock}, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_entry();
        t_rejects();
        t_blocked();
        t_addr();
        t_soft();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule